// File: doc/BRIEF.md
# Infrared Remote Wakeup Pulse Validator

This block watches a demodulated infrared remote-control line and checks the timing of each mark and space against programmable windows. When enough intervals fall inside their windows, it reports that a valid frame has arrived, and a wakeup controller can act on that report. It supports two common remote protocols. RC-5 uses Manchester half-bit cells, and every cell is checked against a single window. NEC uses a long header burst, a header space and pulse-distance data bits, and each of these three phases has its own window.

The line passes through a synchronizer. All durations are then measured in ticks of a prescaled time base; the default divider gives 0.1 ms ticks from a 50 MHz clock. The measuring counter saturates, so a long quiet line can never alias into a valid-looking interval. Each interval is judged once, in the cycle where the edge that closes it is detected. Each accepted bit produces a one-cycle strobe together with its value. A rejected interval produces a one-cycle error pulse and sends the sequencer back to idle. Six limit registers sit behind a byte-wide access port. A synchronous software-reset input returns all six to their power-on values.

Top module: `irw_validator`

## Requirements
- R1: After reset the limit registers read back as: address 0 = 0x07, 1 = 0x0B (window 1 low/high), 2 = 0x50, 3 = 0x64 (window 2 low/high), 4 = 0x28, 5 = 0x32 (window 3 low/high).
- R2: The window 1 limits hold 5 bits, so bits 7:5 read as zero whatever was written. Windows 2 and 3 hold all 8 bits. Addresses 6 and 7 read as zero.
- R3: A one-cycle pulse on `soft_rst` returns all six limits to their R1 values.
- R4: An interval is measured as floor(D / TICK_DIV) ticks, where D is the number of clocks between the two detected edges. The count saturates at 255, so an interval longer than 255 ticks never wraps to a small value.
- R5: With `proto_nec`=0, a rising edge in idle starts a frame. Every later edge closes an interval that must lie in window 1, bounds inclusive. An accepted cell pulses `bit_valid`, and `bit_value` gives the line level during the cell (1 = mark).
- R6: With `proto_nec`=0, the window 2 and window 3 limits have no effect on acceptance.
- R7: With `proto_nec`=1, a rising edge in idle starts a frame. The header mark, closed by the next falling edge, must lie in window 2, bounds inclusive.
- R8: With `proto_nec`=1, the header space, closed by the next rising edge, must lie in window 3, bounds inclusive.
- R9: With `proto_nec`=1, each data bit is the rising-edge-to-rising-edge spacing. A spacing inside window 1 gives bit value 1. Otherwise a spacing inside window 1 with both limits halved (shifted right by one) gives bit value 0. Falling edges inside the data phase are not judged.
- R10: Any interval outside its window raises `err_pulse` for exactly one cycle, never in the same cycle as `bit_valid`, and returns the sequencer to idle. In idle, falling edges are ignored.
- R11: `frame_valid` rises in the same cycle as the FRAME_BITS-th accepted bit of a frame. It stays high until the next frame start, where it clears.
- R12: If the interval count saturates while a frame is in progress, the sequencer returns to idle without raising `err_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous restore of limit registers |
| wr_en | input | 1 | Write strobe for the limit registers |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| proto_nec | input | 1 | Protocol select: 0 = RC-5, 1 = NEC |
| ir_in | input | 1 | Demodulated infrared line, 1 = carrier present |
| bit_valid | output | 1 | One-cycle strobe per accepted bit or cell |
| bit_value | output | 1 | Value of the accepted bit, valid with `bit_valid` |
| err_pulse | output | 1 | One-cycle pulse on an out-of-window interval |
| frame_valid | output | 1 | A complete frame of accepted bits was seen |

## Verification
The assertions assume that `proto_nec` changes only while the sequencer is idle. The RC-5 path check depends on this, because a mode switch in the middle of a frame would leave a NEC-only state reachable under the other setting. The stimulus changes protocol only once, after an RC-5 frame has timed out to idle. The assertions also assume that `ir_in` is a clean level. The bench drives every level for an exact multiple of the tick divider and changes inputs only between clock edges. This keeps every measured interval deterministic, so inclusive window bounds can be probed exactly, one tick inside and one tick outside.

// File: rtl/irw_pkg.sv
package irw_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int LIM_W  = 8;
    localparam int R1_W   = 5;
    localparam int CNT_W  = 8;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    localparam logic [ADDR_W-1:0] A_W1_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_W1_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_W2_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_W2_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_W3_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_W3_HI = 3'd5;

    typedef struct packed {
        logic [R1_W-1:0]  w1_lo;
        logic [R1_W-1:0]  w1_hi;
        logic [LIM_W-1:0] w2_lo;
        logic [LIM_W-1:0] w2_hi;
        logic [LIM_W-1:0] w3_lo;
        logic [LIM_W-1:0] w3_hi;
    } limits_t;

    localparam limits_t LIM_RESET = '{
        w1_lo: 5'h07, w1_hi: 5'h0B,
        w2_lo: 8'h50, w2_hi: 8'h64,
        w3_lo: 8'h28, w3_hi: 8'h32
    };

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CELL,
        ST_HDR_MARK,
        ST_HDR_GAP,
        ST_DATA
    } seq_state_t;

    function automatic logic in_window(input logic [CNT_W-1:0] v,
                                       input logic [CNT_W-1:0] lo,
                                       input logic [CNT_W-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/irw_limit_regs.sv
module irw_limit_regs
    import irw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output limits_t           lim
);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            lim <= LIM_RESET;
        end else if (wr_en) begin
            case (addr)
                A_W1_LO: lim.w1_lo <= wr_data[R1_W-1:0];
                A_W1_HI: lim.w1_hi <= wr_data[R1_W-1:0];
                A_W2_LO: lim.w2_lo <= wr_data[LIM_W-1:0];
                A_W2_HI: lim.w2_hi <= wr_data[LIM_W-1:0];
                A_W3_LO: lim.w3_lo <= wr_data[LIM_W-1:0];
                A_W3_HI: lim.w3_hi <= wr_data[LIM_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_W1_LO: rd_data = DATA_W'(lim.w1_lo);
            A_W1_HI: rd_data = DATA_W'(lim.w1_hi);
            A_W2_LO: rd_data = DATA_W'(lim.w2_lo);
            A_W2_HI: rd_data = DATA_W'(lim.w2_hi);
            A_W3_LO: rd_data = DATA_W'(lim.w3_lo);
            A_W3_HI: rd_data = DATA_W'(lim.w3_hi);
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irw_edge_timer.sv
module irw_edge_timer
    import irw_pkg::*;
#(
    parameter int TICK_DIV = 5000
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             ir_in,
    input  logic             restart,
    output logic             edge_det,
    output logic             rise_det,
    output logic [CNT_W-1:0] iv_cnt,
    output logic             iv_sat
);

    localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
    localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);

    logic [2:0]       sync_q;
    logic [PRE_W-1:0] pre_q;
    logic             tick;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], ir_in};
    end

    assign edge_det = sync_q[2] ^ sync_q[1];
    assign rise_det = sync_q[1] & ~sync_q[2];
    assign tick     = (pre_q == PRE_LAST);
    assign iv_sat   = (iv_cnt == CNT_MAX);

    // The edge cycle itself is the first counted clock of the new interval.
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            iv_cnt <= CNT_MAX;
        end else if (restart) begin
            pre_q  <= PRE_ONE;
            iv_cnt <= '0;
        end else if (tick) begin
            pre_q  <= '0;
            if (!iv_sat) iv_cnt <= iv_cnt + 1'b1;
        end else begin
            pre_q  <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/irw_frame_seq.sv
module irw_frame_seq
    import irw_pkg::*;
#(
    parameter int FRAME_BITS = 32
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             proto_nec,
    input  logic             edge_det,
    input  logic             rise_det,
    input  logic [CNT_W-1:0] iv_cnt,
    input  logic             iv_sat,
    input  limits_t          lim,
    output logic             restart,
    output seq_state_t       state,
    output logic             bit_valid,
    output logic             bit_value,
    output logic             err_pulse,
    output logic             frame_valid
);

    localparam int BC_W = $clog2(FRAME_BITS + 1);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(FRAME_BITS - 1);

    logic [CNT_W-1:0] w1_lo, w1_hi;
    logic             hit1, hit0, hit2, hit3;
    seq_state_t       st_d;
    logic             acc, acc_val, err_d, start;
    logic [BC_W-1:0]  bits_q;

    assign w1_lo = CNT_W'(lim.w1_lo);
    assign w1_hi = CNT_W'(lim.w1_hi);
    assign hit1  = in_window(iv_cnt, w1_lo, w1_hi);
    assign hit0  = in_window(iv_cnt, w1_lo >> 1, w1_hi >> 1);
    assign hit2  = in_window(iv_cnt, lim.w2_lo, lim.w2_hi);
    assign hit3  = in_window(iv_cnt, lim.w3_lo, lim.w3_hi);

    // In the data phase the timer must span mark plus space.
    assign restart = edge_det && !(state == ST_DATA && !rise_det);

    always_comb begin
        st_d    = state;
        acc     = 1'b0;
        acc_val = 1'b0;
        err_d   = 1'b0;
        start   = 1'b0;
        if (edge_det) begin
            case (state)
                ST_IDLE: begin
                    if (rise_det) begin
                        start = 1'b1;
                        st_d  = proto_nec ? ST_HDR_MARK : ST_CELL;
                    end
                end
                ST_CELL: begin
                    if (hit1) begin
                        acc     = 1'b1;
                        acc_val = ~rise_det;
                    end else begin
                        err_d = 1'b1;
                    end
                end
                ST_HDR_MARK: begin
                    if (hit2) st_d = ST_HDR_GAP;
                    else      err_d = 1'b1;
                end
                ST_HDR_GAP: begin
                    if (hit3) st_d = ST_DATA;
                    else      err_d = 1'b1;
                end
                ST_DATA: begin
                    if (rise_det) begin
                        if (hit1) begin
                            acc     = 1'b1;
                            acc_val = 1'b1;
                        end else if (hit0) begin
                            acc     = 1'b1;
                        end else begin
                            err_d = 1'b1;
                        end
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end else if (iv_sat && state != ST_IDLE) begin
            st_d = ST_IDLE;
        end
        if (err_d) st_d = ST_IDLE;
        if (acc && bits_q == BC_LAST) st_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            bit_valid   <= 1'b0;
            bit_value   <= 1'b0;
            err_pulse   <= 1'b0;
            frame_valid <= 1'b0;
            bits_q      <= '0;
        end else begin
            state     <= st_d;
            bit_valid <= acc;
            bit_value <= acc_val;
            err_pulse <= err_d;
            if (start) begin
                frame_valid <= 1'b0;
                bits_q      <= '0;
            end else if (acc) begin
                if (bits_q == BC_LAST) begin
                    frame_valid <= 1'b1;
                    bits_q      <= '0;
                end else begin
                    bits_q <= bits_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/irw_validator.sv
module irw_validator
    import irw_pkg::*;
#(
    parameter int TICK_DIV   = 5000,
    parameter int FRAME_BITS = 32
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              proto_nec,
    input  logic              ir_in,
    output logic              bit_valid,
    output logic              bit_value,
    output logic              err_pulse,
    output logic              frame_valid
);

    limits_t          lim;
    seq_state_t       st;
    logic             edge_det, rise_det, restart, iv_sat;
    logic [CNT_W-1:0] iv_cnt;

    irw_limit_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .lim      (lim)
    );

    irw_edge_timer #(.TICK_DIV(TICK_DIV)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .ir_in    (ir_in),
        .restart  (restart),
        .edge_det (edge_det),
        .rise_det (rise_det),
        .iv_cnt   (iv_cnt),
        .iv_sat   (iv_sat)
    );

    irw_frame_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .proto_nec   (proto_nec),
        .edge_det    (edge_det),
        .rise_det    (rise_det),
        .iv_cnt      (iv_cnt),
        .iv_sat      (iv_sat),
        .lim         (lim),
        .restart     (restart),
        .state       (st),
        .bit_valid   (bit_valid),
        .bit_value   (bit_value),
        .err_pulse   (err_pulse),
        .frame_valid (frame_valid)
    );

endmodule

// File: rtl/irw_validator_chk.sv
module irw_validator_chk
    import irw_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   proto_nec,
    input logic [ADDR_W-1:0]      addr,
    input logic [DATA_W-R1_W-1:0] rd_hi,
    input logic                   bit_valid,
    input logic                   err_pulse,
    input logic                   frame_valid,
    input seq_state_t             state,
    input logic [CNT_W-1:0]       iv_cnt,
    input logic                   iv_sat,
    input logic                   edge_det,
    input logic                   restart
);

    // R2
    w1_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == A_W1_LO || addr == A_W1_HI) |-> rd_hi == '0);

    // R4
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (iv_cnt == CNT_MAX && !restart) |=> iv_cnt == CNT_MAX);

    // R6
    rc5_path_chk: assert property (@(posedge clk) disable iff (rst)
        !proto_nec |-> !(state inside {ST_HDR_MARK, ST_HDR_GAP, ST_DATA}));

    // R10
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> !err_pulse);

    // R10
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bit_valid && err_pulse));

    // R11
    frame_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_valid) |-> bit_valid);

    // R12
    timeout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (iv_sat && !edge_det && state != ST_IDLE) |=> (state == ST_IDLE && !err_pulse));

endmodule

bind irw_validator irw_validator_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .proto_nec   (proto_nec),
    .addr        (addr),
    .rd_hi       (rd_data[irw_pkg::DATA_W-1:irw_pkg::R1_W]),
    .bit_valid   (bit_valid),
    .err_pulse   (err_pulse),
    .frame_valid (frame_valid),
    .state       (st),
    .iv_cnt      (iv_cnt),
    .iv_sat      (iv_sat),
    .edge_det    (edge_det),
    .restart     (restart)
);

// File: tb/test_irw_validator.sv
module test_irw_validator;
    import irw_pkg::*;

    localparam int DIV   = 4;
    localparam int NBITS = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst = 1'b1, soft_rst = 1'b0, wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              proto_nec = 1'b0, ir_in = 1'b0;
    logic              bit_valid, bit_value, err_pulse, frame_valid;

    irw_validator #(.TICK_DIV(DIV), .FRAME_BITS(NBITS)) i_irw_validator (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .proto_nec(proto_nec), .ir_in(ir_in),
        .bit_valid(bit_valid), .bit_value(bit_value), .err_pulse(err_pulse),
        .frame_valid(frame_valid)
    );

    typedef struct { bit is_err; bit val; string tag; } exp_t;
    exp_t q[$];
    exp_t cur;
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Scoreboard monitor: events coded 0/1 = accepted bit value, 2 = error.
    always @(negedge clk) begin
        if (!rst && (bit_valid || err_pulse)) begin
            if (q.size() == 0) begin
                check(0, "R10", "unexpected event", err_pulse ? 2 : int'(bit_value), -1);
            end else begin
                cur = q.pop_front();
                check(err_pulse == cur.is_err && (cur.is_err || bit_value == cur.val),
                      cur.tag, "event", err_pulse ? 2 : int'(bit_value),
                      cur.is_err ? 2 : int'(cur.val));
            end
        end
    end

    task automatic push_bit(bit v, string tag);
        q.push_back('{is_err: 1'b0, val: v, tag: tag});
    endtask

    task automatic push_err(string tag);
        q.push_back('{is_err: 1'b1, val: 1'b0, tag: tag});
    endtask

    task automatic hold(bit v, int ticks);
        ir_in = v;
        repeat (ticks * DIV) @(negedge clk);
    endtask

    task automatic nec_bit(int spacing);
        hold(1'b1, 5);
        hold(1'b0, spacing - 5);
    endtask

    task automatic drain(string tag);
        repeat (10) @(negedge clk);
        check(q.size() == 0, tag, "pending expected events", q.size(), 0);
        q.delete();
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] e, string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(rd_data == e, tag, "register read", rd_data, e);
    endtask

    task automatic pulse_soft_rst();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        check(!bit_valid && !err_pulse && !frame_valid, "R1", "outputs after reset",
              {bit_valid, err_pulse, frame_valid}, 0);
        // R1: reset values
        rd_chk(3'd0, 8'h07, "R1"); rd_chk(3'd1, 8'h0B, "R1");
        rd_chk(3'd2, 8'h50, "R1"); rd_chk(3'd3, 8'h64, "R1");
        rd_chk(3'd4, 8'h28, "R1"); rd_chk(3'd5, 8'h32, "R1");

        // R2: field widths and unmapped addresses
        wr(3'd0, 8'hFF); rd_chk(3'd0, 8'h1F, "R2");
        wr(3'd3, 8'hAB); rd_chk(3'd3, 8'hAB, "R2");
        wr(3'd6, 8'h55); rd_chk(3'd6, 8'h00, "R2");
        rd_chk(3'd7, 8'h00, "R2");

        // R3: software restore
        pulse_soft_rst();
        rd_chk(3'd0, 8'h07, "R3"); rd_chk(3'd3, 8'h64, "R3");

        // R6: nonsense limits on windows 2 and 3 must not matter in RC-5 mode
        wr(3'd2, 8'hFF); wr(3'd3, 8'h00); wr(3'd4, 8'hFF); wr(3'd5, 8'h00);

        // R5, R4, R6, R11: RC-5 frame with inclusive bounds 7 and 11
        hold(1'b0, 20);
        push_bit(1, "R5"); push_bit(0, "R4"); push_bit(1, "R6"); push_bit(0, "R5");
        push_bit(1, "R5"); push_bit(0, "R5"); push_bit(1, "R5"); push_bit(0, "R11");
        hold(1'b1, 7); hold(1'b0, 11);
        hold(1'b1, 9); hold(1'b0, 9); hold(1'b1, 9); hold(1'b0, 9);
        hold(1'b1, 9); hold(1'b0, 9);
        hold(1'b1, 5);
        check(frame_valid == 1'b1, "R11", "frame_valid after last cell", frame_valid, 1);
        hold(1'b0, 30);
        drain("R5");

        // R10: cells one tick outside window 1
        push_err("R10");
        hold(1'b1, 6);
        check(frame_valid == 1'b0, "R11", "frame_valid cleared at frame start", frame_valid, 0);
        hold(1'b0, 30);
        push_err("R4");
        hold(1'b1, 12); hold(1'b0, 30);
        drain("R10");

        // R12, R4: a 300-tick space times out quietly instead of wrapping to 44
        push_bit(1, "R12");
        hold(1'b1, 9); hold(1'b0, 300);
        push_bit(1, "R12");
        hold(1'b1, 9); hold(1'b0, 300);
        drain("R12");

        // NEC setup: restore limits, window 1 = 20..25 (bit 0 window 10..12)
        pulse_soft_rst();
        wr(3'd0, 8'h14); wr(3'd1, 8'h19);
        proto_nec = 1'b1;

        // R7, R8, R9, R11: header 90/45, spacings at every bound
        hold(1'b0, 20);
        push_bit(1, "R9"); push_bit(1, "R9"); push_bit(1, "R9"); push_bit(0, "R9");
        push_bit(0, "R9"); push_bit(0, "R9"); push_bit(1, "R7"); push_bit(0, "R8");
        hold(1'b1, 90); hold(1'b0, 45);
        nec_bit(22); nec_bit(20); nec_bit(25); nec_bit(11);
        nec_bit(10); nec_bit(12); nec_bit(22); nec_bit(11);
        hold(1'b1, 5);
        check(frame_valid == 1'b1, "R11", "frame_valid after NEC frame", frame_valid, 1);
        hold(1'b0, 30);
        drain("R9");

        // R7: header marks just outside window 2
        push_err("R7");
        hold(1'b1, 79); hold(1'b0, 30);
        push_err("R7");
        hold(1'b1, 101); hold(1'b0, 30);
        drain("R7");

        // R8, R10: short header space, then a header-like mark in idle is ignored
        push_err("R8");
        hold(1'b1, 80); hold(1'b0, 39);
        hold(1'b1, 90); hold(1'b0, 30);
        drain("R10");

        // R9: spacing 17 lies between the bit-0 and bit-1 windows
        push_err("R9");
        hold(1'b1, 100); hold(1'b0, 50);
        nec_bit(17);
        hold(1'b1, 5); hold(1'b0, 30);
        drain("R9");
        check(frame_valid == 1'b0, "R11", "frame_valid after failed frame", frame_valid, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule